// File: doc/BRIEF.md
# Multiboot Configuration Loader with Unlock Watchdog

This controller brings up an FPGA from an external byte-wide configuration flash divided into four equal image slots. After reset it reads a one-byte slot selector held just above the image area. It then pulses the FPGA's program line low, waits for the init line, and clocks the selected image out byte by byte. Finally it waits for the done line.

When a user image comes up, a watchdog starts counting. The freshly loaded design proves it is healthy by writing a fixed four-byte unlock code through a narrow write port. If the code does not arrive in time, the image is treated as corrupt. The same applies if a user load stalls before init or before done. In every such case the controller reloads slot 0, which holds the protected factory image, and lights a sticky failure indicator. A factory load never arms the watchdog. A factory load that itself fails parks the controller in a halted state.

Top module: `cfg_wd_loader`

## Requirements
- R1: The selector byte is read from flash address 4·2^SLOT_AW (0x40 by default, just above the four slots). A value of 1, 2 or 3 loads that slot. A value of 0 or any value above 3 loads slot 0. `cur_slot` reports the slot being loaded or running.
- R2: A load drives `prog_n` low for exactly PROG_CYCLES clocks. It then waits for `init_in` high. It then presents IMG_BYTES bytes from flash addresses slot·2^SLOT_AW + 0, 1, 2, … in ascending order on `cfg_data`, one byte per high phase of `cfg_clk`. `cfg_clk` stays low while `prog_n` is low.
- R3: If `init_in` is still low INIT_TMO clocks after `prog_n` returns high, the load has failed.
- R4: If `done_in` has not risen within DONE_TMO clocks after the last byte, the load has failed.
- R5: After a user image reports done, `wd_armed` stays high for exactly WD_CYCLES clocks unless the unlock code arrives. On expiry, a factory reload follows.
- R6: The write sequence 0xA5, 0x5A, 0xC3, 0x3C on `reg_wdata` (each with `reg_wr`) while armed drops `wd_armed`. The user image then keeps running and no fallback occurs.
- R7: Any write that does not match the next expected code byte sends matching back to the first byte. The watchdog stays armed. Thus 0xA5, 0x5A, 0xC3, 0x00, 0x3C does not unlock.
- R8: A failed user load, or an expired watchdog, reloads slot 0 and sets `fail_led`. `cur_slot` reads 0 from then on.
- R9: `fail_led` stays set until the next reset and is low after reset.
- R10: A slot 0 load ends with `cfg_ok` high and `wd_armed` low. Register writes then have no effect.
- R11: A failed slot 0 load raises `halted`. `halted` stays high and `cfg_ok` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_rd | output | 1 | Flash read strobe; data is returned the following cycle |
| flash_addr | output | SLOT_AW+3 | Flash byte address |
| flash_data | input | 8 | Flash read data |
| prog_n | output | 1 | FPGA program line, active low |
| init_in | input | 1 | FPGA init line, high when ready for data |
| done_in | input | 1 | FPGA done line |
| cfg_clk | output | 1 | Configuration data clock |
| cfg_data | output | 8 | Configuration data byte |
| reg_wr | input | 1 | Write strobe from the loaded design |
| reg_wdata | input | 8 | Write data from the loaded design |
| cur_slot | output | 2 | Slot currently loaded or being loaded |
| cfg_ok | output | 1 | An image has reported done and is running |
| wd_armed | output | 1 | Watchdog counting for a user image |
| fail_led | output | 1 | Sticky fallback indicator |
| halted | output | 1 | Factory image failed to load |

## Verification
A corrupted sequencer state shows at the ports within one load. Symptoms include the wrong `cur_slot`, a byte stream taken from the wrong addresses or in the wrong order, a program pulse of the wrong length, or `cfg_ok` never rising. A broken watchdog count or unlock matcher shows as a `wd_armed` window that is not exactly WD_CYCLES long, or as a fallback after a correct code, at most WD_CYCLES clocks after done. Faulty failure handling shows as a missing or cleared `fail_led`, a watchdog armed on the factory image, or a missing `halted` after a factory failure, all within one timeout window.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;
  typedef enum logic [3:0] {
    ST_FLAG_RD,
    ST_FLAG_CAP,
    ST_PROG,
    ST_INIT,
    ST_FETCH,
    ST_SHIFT,
    ST_CLK,
    ST_DONE,
    ST_RUN_USR,
    ST_RUN_OK,
    ST_RUN_FAC,
    ST_HALT
  } ldr_state_e;
endpackage

// File: rtl/cfgwd_timer.sv
module cfgwd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr || en) cnt <= cnt_d;
  end
endmodule

// File: rtl/cfgwd_unlock.sv
module cfgwd_unlock #(
  parameter int          KEY_WORDS = 4,
  parameter logic [31:0] KEY       = 32'hA55A_C33C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       hit
);
  localparam int PW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam logic [PW-1:0] LAST = PW'(KEY_WORDS - 1);

  logic [PW-1:0] pos_q, pos_d;
  logic [7:0]    want;
  logic          match;

  assign want  = KEY[8*(KEY_WORDS-1-int'(pos_q)) +: 8];
  assign match = en && wr && (wdata == want);
  assign hit   = match && (pos_q == LAST);

  always_comb begin
    pos_d = pos_q;
    if (!en)                    pos_d = '0;
    else if (wr && !match)      pos_d = '0;
    else if (match && hit)      pos_d = '0;
    else if (match)             pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (wr || !en) pos_q <= pos_d;
  end
endmodule

// File: rtl/cfgwd_seq.sv
module cfgwd_seq
  import cfgwd_pkg::*;
#(
  parameter int SLOT_AW     = 4,
  parameter int IMG_BYTES   = 12,
  parameter int PROG_CYCLES = 4,
  parameter int INIT_TMO    = 40,
  parameter int DONE_TMO    = 120,
  parameter int WD_CYCLES   = 300,
  parameter int TW          = 9,
  localparam int FAW        = SLOT_AW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           flash_rd,
  output logic [FAW-1:0] flash_addr,
  input  logic [7:0]     flash_data,
  output logic           prog_n,
  input  logic           init_in,
  input  logic           done_in,
  output logic           cfg_clk,
  output logic [7:0]     cfg_data,
  input  logic           unlock_hit,
  input  logic [TW-1:0]  tmr_cnt,
  output logic           tmr_clr,
  output logic           tmr_en,
  output logic [1:0]     cur_slot,
  output logic           cfg_ok,
  output logic           wd_armed,
  output logic           fail_led,
  output logic           halted
);
  localparam logic [FAW-1:0]     FLAG_ADDR = FAW'(4) << SLOT_AW;
  localparam logic [SLOT_AW-1:0] LAST_IDX  = SLOT_AW'(IMG_BYTES - 1);

  ldr_state_e         state_q, state_d;
  logic [1:0]         slot_q, slot_d;
  logic               led_q, led_d;
  logic [SLOT_AW-1:0] idx_q, idx_d;
  logic [7:0]         cdat_q;
  logic               fail;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    led_d   = led_q;
    idx_d   = idx_q;
    fail    = 1'b0;
    case (state_q)
      ST_FLAG_RD:  state_d = ST_FLAG_CAP;
      ST_FLAG_CAP: begin
        slot_d  = (flash_data != 8'd0 && flash_data < 8'd4) ? flash_data[1:0] : 2'd0;
        state_d = ST_PROG;
      end
      ST_PROG: begin
        idx_d = '0;
        if (tmr_cnt == TW'(PROG_CYCLES - 1)) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (init_in) state_d = ST_FETCH;
        else if (tmr_cnt == TW'(INIT_TMO - 1)) fail = 1'b1;
      end
      ST_FETCH: state_d = ST_SHIFT;
      ST_SHIFT: state_d = ST_CLK;
      ST_CLK: begin
        if (idx_q == LAST_IDX) state_d = ST_DONE;
        else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_DONE: begin
        if (done_in) state_d = (slot_q != 2'd0) ? ST_RUN_USR : ST_RUN_FAC;
        else if (tmr_cnt == TW'(DONE_TMO - 1)) fail = 1'b1;
      end
      ST_RUN_USR: begin
        if (unlock_hit) state_d = ST_RUN_OK;
        else if (tmr_cnt == TW'(WD_CYCLES - 1)) fail = 1'b1;
      end
      default: ;
    endcase
    if (fail) begin
      if (slot_q != 2'd0) begin
        slot_d  = 2'd0;
        led_d   = 1'b1;
        state_d = ST_PROG;
      end else begin
        state_d = ST_HALT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLAG_RD;
      slot_q  <= 2'd0;
      led_q   <= 1'b0;
      idx_q   <= '0;
      cdat_q  <= 8'd0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      led_q   <= led_d;
      if (state_q == ST_PROG || state_q == ST_CLK) idx_q <= idx_d;
      if (state_q == ST_SHIFT) cdat_q <= flash_data;
    end
  end

  assign tmr_clr    = (state_d != state_q);
  assign tmr_en     = (state_q == ST_PROG) || (state_q == ST_INIT) ||
                      (state_q == ST_DONE) || (state_q == ST_RUN_USR);
  assign flash_rd   = (state_q == ST_FLAG_RD) || (state_q == ST_FETCH);
  assign flash_addr = (state_q == ST_FLAG_RD) ? FLAG_ADDR : {1'b0, slot_q, idx_q};
  assign prog_n     = (state_q != ST_PROG);
  assign cfg_clk    = (state_q == ST_CLK);
  assign cfg_data   = cdat_q;
  assign cur_slot   = slot_q;
  assign wd_armed   = (state_q == ST_RUN_USR);
  assign cfg_ok     = (state_q == ST_RUN_USR) || (state_q == ST_RUN_OK) ||
                      (state_q == ST_RUN_FAC);
  assign fail_led   = led_q;
  assign halted     = (state_q == ST_HALT);

  a_r9_led_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_led |=> fail_led);
  a_r10_wd_user_only: assert property (@(posedge clk) disable iff (!rst_n)
    wd_armed |-> (cur_slot != 2'd0));
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r8_fallback_factory: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_led) |-> (cur_slot == 2'd0) && !prog_n);
  a_r2_clk_idle_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !cfg_clk);
  a_r6_unlock_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_armed && unlock_hit) |=> (!wd_armed && cfg_ok && !fail_led));
endmodule

// File: rtl/cfg_wd_loader.sv
module cfg_wd_loader #(
  parameter int          SLOT_AW     = 4,
  parameter int          IMG_BYTES   = 12,
  parameter int          PROG_CYCLES = 4,
  parameter int          INIT_TMO    = 40,
  parameter int          DONE_TMO    = 120,
  parameter int          WD_CYCLES   = 1 << 20,
  parameter logic [31:0] UNLOCK_KEY  = 32'hA55A_C33C,
  localparam int         FAW         = SLOT_AW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           flash_rd,
  output logic [FAW-1:0] flash_addr,
  input  logic [7:0]     flash_data,
  output logic           prog_n,
  input  logic           init_in,
  input  logic           done_in,
  output logic           cfg_clk,
  output logic [7:0]     cfg_data,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [1:0]     cur_slot,
  output logic           cfg_ok,
  output logic           wd_armed,
  output logic           fail_led,
  output logic           halted
);
  localparam int TMAX1 = (WD_CYCLES > DONE_TMO) ? WD_CYCLES : DONE_TMO;
  localparam int TMAX2 = (INIT_TMO > PROG_CYCLES) ? INIT_TMO : PROG_CYCLES;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW    = $clog2(TMAX + 1);

  logic          rs_meta, rs_n;
  logic          tmr_clr, tmr_en, unlock_hit;
  logic [TW-1:0] tmr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  cfgwd_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rs_n), .clr(tmr_clr), .en(tmr_en), .cnt(tmr_cnt)
  );

  cfgwd_unlock #(.KEY_WORDS(4), .KEY(UNLOCK_KEY)) u_unl (
    .clk(clk), .rst_n(rs_n), .en(wd_armed), .wr(reg_wr), .wdata(reg_wdata),
    .hit(unlock_hit)
  );

  cfgwd_seq #(
    .SLOT_AW(SLOT_AW), .IMG_BYTES(IMG_BYTES), .PROG_CYCLES(PROG_CYCLES),
    .INIT_TMO(INIT_TMO), .DONE_TMO(DONE_TMO), .WD_CYCLES(WD_CYCLES), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rs_n),
    .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_data(flash_data),
    .prog_n(prog_n), .init_in(init_in), .done_in(done_in),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .unlock_hit(unlock_hit), .tmr_cnt(tmr_cnt), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
    .cur_slot(cur_slot), .cfg_ok(cfg_ok), .wd_armed(wd_armed),
    .fail_led(fail_led), .halted(halted)
  );
endmodule

// File: tb/sim_cfg_wd_loader.sv
`timescale 1ns/1ps
module sim_cfg_wd_loader;
  localparam int SLOT_AW = 4;
  localparam int IMG     = 12;
  localparam int PROGC   = 4;
  localparam int INIT_T  = 40;
  localparam int DONE_T  = 120;
  localparam int WD      = 300;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       flash_rd;
  logic [6:0] flash_addr;
  logic [7:0] flash_data = 0;
  logic       prog_n, cfg_clk, cfg_ok, wd_armed, fail_led, halted;
  logic [7:0] cfg_data;
  logic [1:0] cur_slot;
  logic       init_in = 0, done_in = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0;

  int vecs = 0, errs = 0;
  logic [7:0] flag = 0;
  logic [3:0] good = 4'hF;
  int init_block = 0;
  int nbytes = 0, bad_bytes = 0, low_run = 0, last_low = 0, dly = 0;

  always #2.5 clk = ~clk;

  cfg_wd_loader #(.SLOT_AW(SLOT_AW), .IMG_BYTES(IMG), .PROG_CYCLES(PROGC),
    .INIT_TMO(INIT_T), .DONE_TMO(DONE_T), .WD_CYCLES(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .flash_rd(flash_rd), .flash_addr(flash_addr),
    .flash_data(flash_data), .prog_n(prog_n), .init_in(init_in), .done_in(done_in),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cur_slot(cur_slot), .cfg_ok(cfg_ok), .wd_armed(wd_armed),
    .fail_led(fail_led), .halted(halted));

  function automatic logic [7:0] img_byte(input int slot, input int i);
    return 8'((slot * 53) ^ (i * 11) ^ 8'h96);
  endfunction

  function automatic int exp_slot(input logic [7:0] f);
    return (f >= 8'd1 && f <= 8'd3) ? int'(f) : 0;
  endfunction

  always @(posedge clk)
    if (flash_rd) flash_data <= flash_addr[6] ? flag : img_byte(int'(flash_addr[5:4]), int'(flash_addr[3:0]));

  // FPGA model, updated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      init_in = 0; done_in = 0; nbytes = 0; low_run = 0; dly = 0;
    end else if (!prog_n) begin
      init_in = 0; done_in = 0; nbytes = 0; dly = 0; low_run++;
    end else begin
      if (low_run != 0) begin
        last_low = low_run; low_run = 0;
        if (init_block > 0) begin init_block--; dly = -1000000; end
      end
      if (!init_in) begin dly++; if (dly >= 3) init_in = 1; end
      if (cfg_clk) begin
        if (nbytes >= IMG || cfg_data !== img_byte(int'(cur_slot), nbytes)) bad_bytes++;
        nbytes++;
      end
      if (init_in && nbytes == IMG && good[cur_slot]) done_in = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; reg_wr = 0; bad_bytes = 0; last_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_settled(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (cfg_ok || halted) break;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic send_key();
    wr(8'hA5); wr(8'h5A); wr(8'hC3); wr(8'h3C);
  endtask

  initial begin
    #(200000 * 5);
    errs++; vecs++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] j;
    void'($urandom(32'd1234));

    // R9 reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(prog_n === 1 && !fail_led && !wd_armed && !halted && !cfg_ok, "R9 reset state", int'(fail_led), 0);

    // R1 R2 R6: user slot 2, unlock
    flag = 8'd2; good = 4'hF; do_reset(); wait_settled(500);
    chk(cur_slot == 2, "R1 slot select", int'(cur_slot), 2);
    chk(wd_armed === 1, "R5 armed after user load", int'(wd_armed), 1);
    chk(last_low == PROGC, "R2 program pulse length", last_low, PROGC);
    chk(nbytes == IMG && bad_bytes == 0, "R2 byte stream", bad_bytes, 0);
    send_key(); @(negedge clk);
    chk(!wd_armed && cfg_ok, "R6 unlock disarms", int'(wd_armed), 0);
    repeat (WD + 20) @(negedge clk);
    chk(!fail_led && cur_slot == 2 && cfg_ok, "R6 no fallback after unlock", int'(fail_led), 0);

    // R1 R10: flag 0 and out of range go to factory
    flag = 8'd0; do_reset(); wait_settled(500);
    chk(cur_slot == 0 && cfg_ok && !wd_armed, "R1 flag zero factory", int'(cur_slot), 0);
    send_key(); wr(8'h00);
    repeat (WD + 20) @(negedge clk);
    chk(cfg_ok && !wd_armed && !fail_led && !halted, "R10 factory runs unguarded", int'(wd_armed), 0);
    flag = 8'd7; do_reset(); wait_settled(500);
    chk(cur_slot == 0 && !wd_armed && !fail_led, "R1 out of range flag", int'(cur_slot), 0);

    // R1 R2 R6: random flags with random junk before the key
    for (int it = 0; it < 8; it++) begin
      flag = (it % 2 == 0) ? 8'($urandom % 4) : 8'($urandom);
      do_reset(); wait_settled(500);
      chk(int'(cur_slot) == exp_slot(flag), "R1 random flag", int'(cur_slot), exp_slot(flag));
      chk(bad_bytes == 0 && nbytes == IMG, "R2 random stream", bad_bytes, 0);
      if (cur_slot != 0) begin
        n = 1 + ($urandom % 4);
        for (int k = 0; k < n; k++) begin
          j = 8'($urandom); if (j == 8'hA5) j = 8'h00;
          wr(j);
        end
        chk(wd_armed === 1, "R7 junk keeps armed", int'(wd_armed), 1);
        send_key(); @(negedge clk);
        chk(!wd_armed && !fail_led, "R6 key after junk", int'(wd_armed), 0);
      end
    end

    // R5 R8 R9: watchdog expiry window length
    flag = 8'd1; do_reset(); wait_settled(500);
    n = 0;
    while (wd_armed && n < WD + 50) begin n++; @(negedge clk); end
    chk(n == WD, "R5 watchdog window", n, WD);
    chk(fail_led && cur_slot == 0, "R8 fallback on expiry", int'(fail_led), 1);
    wait_settled(500);
    chk(cfg_ok && !wd_armed && cur_slot == 0, "R8 factory loaded", int'(cfg_ok), 1);
    repeat (50) @(negedge clk);
    chk(fail_led === 1, "R9 led sticky", int'(fail_led), 1);

    // R7 wrong word restarts matching
    flag = 8'd3; do_reset(); wait_settled(500);
    wr(8'hA5); wr(8'h5A); wr(8'hC3); wr(8'h00); wr(8'h3C); @(negedge clk);
    chk(wd_armed === 1, "R7 broken key ignored", int'(wd_armed), 1);
    wr(8'hA5); wr(8'h5A); wr(8'h00); send_key(); @(negedge clk);
    chk(!wd_armed && !fail_led && cur_slot == 3, "R7 restart then key", int'(wd_armed), 0);

    // R4 R8: done timeout on user image
    flag = 8'd3; good = 4'b0111; do_reset(); wait_settled(1000);
    chk(fail_led && cur_slot == 0 && cfg_ok && !halted, "R4 done timeout fallback", int'(fail_led), 1);

    // R3 R8: init timeout on the first load only
    flag = 8'd2; good = 4'hF; init_block = 1; do_reset(); wait_settled(1000);
    chk(fail_led && cur_slot == 0 && cfg_ok, "R3 init timeout fallback", int'(fail_led), 1);
    chk(bad_bytes == 0, "R2 factory stream after fallback", bad_bytes, 0);

    // R11: factory failure halts
    flag = 8'd0; good = 4'b1110; do_reset(); wait_settled(1000);
    chk(halted && !cfg_ok && !fail_led, "R11 factory fail halts", int'(halted), 1);
    repeat (300) @(negedge clk);
    chk(halted && !cfg_ok, "R11 halt sticky", int'(halted), 1);
    flag = 8'd1; good = 4'b1100; do_reset(); wait_settled(2000);
    chk(halted && fail_led && cur_slot == 0, "R11 user then factory fail", int'(halted), 1);

    // R9 reset clears led
    good = 4'hF; do_reset(); @(negedge clk);
    chk(!fail_led && !halted, "R9 reset clears led", int'(fail_led), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule